// File: doc/BRIEF.md
# Multi-Channel ADC Sample Sequencer

This block drives an external successive-approximation converter through a programmable schedule of up to eight channel numbers. Software loads a list of 3-bit channel numbers and the index of the last list entry to use, picks an inter-sample delay, then enables the engine and pulses start. The engine requests one conversion per list entry over a request/acknowledge port. Each returned code is tagged with its channel number and written into a 32-entry result queue, which software reads back as a valid/ready stream.

In single-pass mode the engine walks entries 0 through the last index once and then goes idle. In continuous mode it wraps back to entry 0 and keeps going until told to stop. A stop request lets the conversion in flight finish and keeps the engine busy until an external averaging block reports idle, then clears the enable. A status word reports the busy flags of each sub-engine, the queue level and flags, and the channel at the current list position. An interrupt fires when the queue level reaches a programmable threshold.

The read port follows valid/ready rules. `rd_valid` is high whenever the queue holds an entry, and `rd_data` shows the oldest entry. While `rd_ready` is low, both stay stable. A beat with both high removes that entry at the clock edge. The converter port is the other direction: `conv_req` and `conv_chan` stay asserted until `conv_ack` is seen high at a clock edge, and the code on `conv_code` is captured at that edge.

Top module: `adc_seq_engine`

## Requirements
- R1: After reset there is no conversion request, `rd_valid` and `irq` are low, status bit 28 (sample busy) is 0, status bit 26 (queue empty) is 1 and the count field in status bits 25:21 is 0.
- R2: Register writes use `reg_addr` 0 for control, 1 for the channel list and 2 for the delay. In the control word, bit 0 is enable, bit 1 is continuous, bit 3 is interrupt enable and bits 8:4 are the threshold; these are stored. Bit 2 (start) and bit 14 (stop) act as one-cycle pulses. A start is ignored unless enable was already set before that write and the engine is idle, and a start written together with stop is ignored.
- R3: The list word holds entry i in bits 3i+2:3i and the last index in bits 26:24. After a start the engine converts entries 0 to last index in order, one result per entry, and in single-pass mode it then goes idle.
- R4: In continuous mode, the entry after the last index is entry 0 again.
- R5: Between the acknowledge of one conversion and the next request, `conv_req` is low for exactly (count+1) x 4^sel cycles, where count is delay bits 7:0 and sel is delay bits 9:8. While this gap runs, status bit 30 is 1 and no request is made.
- R6: `conv_req` stays high until acknowledged. The acknowledged code is stored with the channel that was requested.
- R7: `rd_data` bits 14:12 carry the channel, bits 11:0 the code and bit 15 is 0. Entries leave in arrival order, one per beat with `rd_valid` and `rd_ready` both high. Without `rd_ready`, `rd_valid` and `rd_data` hold.
- R8: The queue holds 32 entries. A result that arrives while the queue is full and no entry is read in that cycle is dropped, and status bit 27 (full) stays 1. A result that arrives in the same cycle as a read of a full queue is kept, and the level stays 32.
- R9: Status bit 28 is 1 from start until the engine is idle again. Bit 29 mirrors `avg_busy`. Bits 25:21 carry the low five bits of the queue level. Bits 18:16 carry the channel of the current list entry.
- R10: `irq` is high exactly when interrupt enable is set and the queue level is at least the threshold.
- R11: After a stop, the conversion in flight completes but no new request starts. Status bit 28 stays 1 while `avg_busy` is high. When the engine goes idle the enable bit is cleared, so a later start has no effect until enable is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 channel list, 2 delay |
| reg_wdata | input | 32 | Register write data |
| status | output | 32 | Busy flags, queue flags and level, current channel |
| irq | output | 1 | Queue-level interrupt |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 3 | Channel to convert |
| conv_ack | input | 1 | Converter acknowledge; code valid in this cycle |
| conv_code | input | 12 | Raw conversion code |
| avg_busy | input | 1 | Busy flag from the averaging block |
| rd_valid | output | 1 | Result queue holds an entry |
| rd_ready | input | 1 | Consumer takes the head entry |
| rd_data | output | 16 | Head entry: channel and code |

## Verification
The result queue can see a write from a converter acknowledge and a read from the consumer in the same clock, and the case that matters is when the queue is already full. The bench fills the queue in continuous mode without reading, stops the engine, then runs a one-entry pass on a new channel. In the acknowledge cycle of that pass it raises `rd_ready` together with `conv_ack`. It checks that the level stays at 32 with the full flag set. It then drains the queue and checks that the oldest entry is gone and the last entry carries the new channel.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  // channel numbering and list geometry (status layout depends on these)
  localparam int CH_W      = 3;
  localparam int NUM_SLOTS = 8;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int LIST_W    = NUM_SLOTS * CH_W;
  localparam int LVL_W     = 5;  // width of the level field in status

  // register selects
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_LIST  = 2'd1;
  localparam logic [1:0] SEL_DELAY = 2'd2;

  // control word bits
  localparam int C_ENABLE = 0;
  localparam int C_CONT   = 1;
  localparam int C_START  = 2;
  localparam int C_IRQEN  = 3;
  localparam int C_THR_LO = 4;
  localparam int C_STOP   = 14;

  // list word: last index position
  localparam int L_LAST_LO = 24;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CONV  = 2'd1,
    SQ_GAP   = 2'd2,
    SQ_DRAIN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop_req,
  output logic                       out_valid,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] lvl_q;
  logic          pop_ok, push_ok;

  assign full      = (lvl_q == CW'(DEPTH));
  assign empty     = (lvl_q == '0);
  assign pop_ok    = pop_req && !empty;
  assign push_ok   = push && (!full || pop_ok);
  assign out_valid = !empty;
  assign out_data  = mem[rptr];
  assign level     = lvl_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req) |=> full);

  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_req) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/adcseq_gap_timer.sv
module adcseq_gap_timer #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             busy,
  output logic             done
);
  localparam int TW = CNT_W + 1 + STEP * ((1 << SEL_W) - 1);

  logic [TW-1:0] rem;
  logic [TW-1:0] units, total;

  always_comb begin
    units = TW'(cnt) + TW'(1);
    total = units << (STEP * int'(sel));
  end

  assign done = busy && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      rem  <= total - TW'(1);
    end else if (busy) begin
      if (rem == '0) busy <= 1'b0;
      else           rem  <= rem - 1'b1;
    end
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int DLY_CNT_W = 8,
  parameter int DLY_SEL_W = 2,
  parameter int DLY_STEP  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cont,
  input  logic                   start_p,
  input  logic                   stop_p,
  input  logic [LIST_W-1:0]      chan_list,
  input  logic [IDX_W-1:0]       last_idx,
  input  logic [DLY_CNT_W-1:0]   dly_cnt,
  input  logic [DLY_SEL_W-1:0]   dly_sel,
  output logic                   conv_req,
  output logic [CH_W-1:0]        conv_chan,
  input  logic                   conv_ack,
  input  logic [CODE_W-1:0]      conv_code,
  input  logic                   avg_busy,
  output logic                   push,
  output logic [CH_W+CODE_W-1:0] push_data,
  output logic                   seq_busy,
  output logic                   gap_busy,
  output logic [CH_W-1:0]        cur_chan,
  output logic                   clr_en
);
  seq_state_t     state;
  logic [IDX_W-1:0] idx;
  logic           stop_pend;
  logic           accepted, at_last, halting, go_gap;
  logic           tmr_load, tmr_abort, tmr_done;

  assign cur_chan  = chan_list[idx*CH_W +: CH_W];
  assign conv_chan = cur_chan;
  assign conv_req  = (state == SQ_CONV);
  assign seq_busy  = (state != SQ_IDLE);

  assign accepted  = conv_req && conv_ack;
  assign at_last   = (idx == last_idx);
  assign halting   = stop_p || stop_pend;
  assign go_gap    = accepted && !halting && (!at_last || cont);
  assign push      = accepted;
  assign push_data = {conv_chan, conv_code};

  assign tmr_load  = go_gap;
  assign tmr_abort = (state == SQ_GAP) && stop_p;
  assign clr_en    = (state == SQ_DRAIN) && !avg_busy && halting;

  adcseq_gap_timer #(
    .CNT_W (DLY_CNT_W),
    .SEL_W (DLY_SEL_W),
    .STEP  (DLY_STEP)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .abort (tmr_abort),
    .cnt   (dly_cnt),
    .sel   (dly_sel),
    .busy  (gap_busy),
    .done  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      idx       <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (stop_p) begin
            stop_pend <= 1'b1;
            state     <= SQ_DRAIN;
          end else if (start_p) begin
            idx   <= '0;
            state <= SQ_CONV;
          end
        end
        SQ_CONV: begin
          if (stop_p) stop_pend <= 1'b1;
          if (accepted) begin
            if (go_gap) begin
              idx   <= at_last ? '0 : idx + 1'b1;
              state <= SQ_GAP;
            end else begin
              state <= SQ_DRAIN;
            end
          end
        end
        SQ_GAP: begin
          if (stop_p) begin
            stop_pend <= 1'b1;
            state     <= SQ_DRAIN;
          end else if (tmr_done) begin
            state <= SQ_CONV;
          end
        end
        default: begin
          if (stop_p) stop_pend <= 1'b1;
          if (!avg_busy) begin
            stop_pend <= 1'b0;
            state     <= SQ_IDLE;
          end
        end
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_ack) |=> conv_req);

  // R5
  gap_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> !conv_req);

  // R11
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |-> !$past(avg_busy));
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adcseq_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int CODE_W    = 12,
  parameter int DLY_CNT_W = 8,
  parameter int DLY_SEL_W = 2,
  parameter int DLY_STEP  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          status,
  output logic                 irq,
  output logic                 conv_req,
  output logic [CH_W-1:0]      conv_chan,
  input  logic                 conv_ack,
  input  logic [CODE_W-1:0]    conv_code,
  input  logic                 avg_busy,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [CH_W+CODE_W:0] rd_data
);
  localparam int ENT_W = CH_W + CODE_W;
  localparam int LVL_CW = $clog2(DEPTH) + 1;

  logic                 en_q, cont_q, irqen_q;
  logic [LVL_W-1:0]     thr_q;
  logic [LIST_W-1:0]    list_q;
  logic [IDX_W-1:0]     last_q;
  logic [DLY_CNT_W-1:0] dcnt_q;
  logic [DLY_SEL_W-1:0] dsel_q;

  logic wr_ctrl, wr_list, wr_dly, start_p, stop_p, clr_en;
  logic push, seq_busy, gap_busy, q_full, q_empty;
  logic [ENT_W-1:0]  push_data, head;
  logic [LVL_CW-1:0] level;
  logic [CH_W-1:0]   cur_chan;
  logic              unused_bits;

  assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
  assign wr_list = reg_wr && (reg_addr == SEL_LIST);
  assign wr_dly  = reg_wr && (reg_addr == SEL_DELAY);
  assign stop_p  = wr_ctrl && reg_wdata[C_STOP];
  assign start_p = wr_ctrl && reg_wdata[C_START] && en_q && !reg_wdata[C_STOP];
  assign unused_bits = ^{reg_wdata[31:27], reg_wdata[13:10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cont_q  <= 1'b0;
      irqen_q <= 1'b0;
      thr_q   <= '0;
      list_q  <= '0;
      last_q  <= '0;
      dcnt_q  <= '0;
      dsel_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata[C_ENABLE];
        cont_q  <= reg_wdata[C_CONT];
        irqen_q <= reg_wdata[C_IRQEN];
        thr_q   <= reg_wdata[C_THR_LO +: LVL_W];
      end
      if (clr_en) en_q <= 1'b0;
      if (wr_list) begin
        list_q <= reg_wdata[LIST_W-1:0];
        last_q <= reg_wdata[L_LAST_LO +: IDX_W];
      end
      if (wr_dly) begin
        dcnt_q <= reg_wdata[DLY_CNT_W-1:0];
        dsel_q <= reg_wdata[DLY_CNT_W +: DLY_SEL_W];
      end
    end
  end

  adcseq_ctrl #(
    .CODE_W    (CODE_W),
    .DLY_CNT_W (DLY_CNT_W),
    .DLY_SEL_W (DLY_SEL_W),
    .DLY_STEP  (DLY_STEP)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cont      (cont_q),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .chan_list (list_q),
    .last_idx  (last_q),
    .dly_cnt   (dcnt_q),
    .dly_sel   (dsel_q),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .conv_ack  (conv_ack),
    .conv_code (conv_code),
    .avg_busy  (avg_busy),
    .push      (push),
    .push_data (push_data),
    .seq_busy  (seq_busy),
    .gap_busy  (gap_busy),
    .cur_chan  (cur_chan),
    .clr_en    (clr_en)
  );

  adcseq_fifo #(
    .DEPTH (DEPTH),
    .W     (ENT_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop_req   (rd_ready),
    .out_valid (rd_valid),
    .out_data  (head),
    .level     (level),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign rd_data = {1'b0, head};
  assign irq     = irqen_q && (level >= LVL_CW'(thr_q));

  assign status = {1'b0, gap_busy, avg_busy, seq_busy, q_full, q_empty,
                   level[LVL_W-1:0], 2'b00, cur_chan, 16'h0000};

  // R10
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && thr_q != '0) |-> !irq);

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !en_q) |=> !conv_req);
endmodule

// File: tb/tb_adc_seq_engine.sv
module tb_adc_seq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status;
  logic        irq, conv_req, conv_ack = 1'b0, avg_busy = 1'b0;
  logic [2:0]  conv_chan;
  logic [11:0] conv_code = '0;
  logic        rd_valid, rd_ready, rd_rdy = 1'b0, pop_pulse = 1'b0, pop_on_ack = 1'b0;
  logic [15:0] rd_data;

  int nchk = 0, nfail = 0;
  int lat = 0, low = 0, last_gap = 0;
  bit seen = 0;

  assign rd_ready = rd_rdy | pop_pulse;

  always #2 clk = ~clk;

  adc_seq_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .irq(irq), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_code(conv_code),
    .avg_busy(avg_busy), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  function automatic logic [11:0] code_of(input logic [2:0] ch);
    return {ch, ch, ch, ch} ^ 12'h5A5;
  endfunction

  // converter model: acknowledge on the second sampled cycle of a request
  always @(negedge clk) begin
    if (conv_ack) begin
      conv_ack  = 1'b0;
      pop_pulse = 1'b0;
      lat       = 0;
    end else if (conv_req) begin
      if (lat == 1) begin
        conv_ack  = 1'b1;
        conv_code = code_of(conv_chan);
        pop_pulse = pop_on_ack;
      end else lat++;
    end
  end

  // request gap monitor
  always @(negedge clk) begin
    if (conv_req) begin
      if (seen && low > 0) last_gap = low;
      seen = 1;
      low  = 0;
    end else if (seen) low++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pop1(output logic [15:0] d);
    while (!rd_valid) @(negedge clk);
    d = rd_data;
    rd_rdy = 1'b1;
    @(negedge clk);
    rd_rdy = 1'b0;
  endtask

  task automatic wait_idle();
    while (status[28]) @(negedge clk);
  endtask

  // {list, last index, delay count, delay select}
  localparam logic [36:0] SCN [4] = '{
    {24'o76543210, 3'd7, 8'd0, 2'd0},
    {24'o01234567, 3'd2, 8'd3, 2'd1},
    {24'o00000633, 3'd2, 8'd9, 2'd0},
    {24'o00000006, 3'd0, 8'd1, 2'd3}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int bad;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(conv_req == 0, "R1 conv_req", conv_req, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(status[28] == 0, "R1 busy", status[28], 0);
    chk(status[26] == 1 && status[25:21] == 0, "R1 empty", status[26:21], 32);

    // R2 start ignored while disabled, also when enable is written with start
    wr(0, 32'h4);
    bad = 0;
    repeat (20) begin @(negedge clk); if (conv_req) bad++; end
    chk(bad == 0, "R2 start without enable", bad, 0);
    wr(0, 32'h5);
    bad = 0;
    repeat (20) begin @(negedge clk); if (conv_req) bad++; end
    chk(bad == 0, "R2 start with enable in same write", bad, 0);

    // table of single-pass schedules: R3, R5, R6, R7, R9
    for (int s = 0; s < 4; s++) begin
      logic [23:0] lst;
      logic [2:0]  lasti;
      logic [7:0]  cnt;
      logic [1:0]  sel;
      int n, gap;
      bit saw_gap;
      {lst, lasti, cnt, sel} = SCN[s];
      n   = int'(lasti) + 1;
      gap = (int'(cnt) + 1) << (2 * int'(sel));
      wr(2, {22'b0, sel, cnt});
      wr(1, {5'b0, lasti, lst});
      wr(0, 32'h1);
      wr(0, 32'h5);
      chk(conv_req && conv_chan == lst[2:0], "R3 first request", conv_chan, lst[2:0]);
      chk(status[18:16] == lst[2:0], "R9 current channel", status[18:16], lst[2:0]);
      saw_gap = 0;
      while (status[28]) begin
        if (status[30]) saw_gap = 1;
        @(negedge clk);
      end
      chk(status[25:21] == n, "R3 result count", status[25:21], n);
      if (n > 1) begin
        chk(last_gap == gap, "R5 gap length", last_gap, gap);
        chk(saw_gap, "R5 delta busy", saw_gap, 1);
      end
      for (int k = 0; k < n; k++) begin
        logic [2:0] ech;
        ech = lst[3*k +: 3];
        pop1(d);
        chk(d[14:12] == ech && d[15] == 0, "R3 R7 tag order", d[14:12], ech);
        chk(d[11:0] == code_of(ech), "R6 code", d[11:0], code_of(ech));
      end
      chk(rd_valid == 0, "R7 drained", rd_valid, 0);
    end

    // R4 R8: continuous fill without reading, then stop
    wr(2, 32'h0);
    wr(1, {5'b0, 3'd1, 24'o00000021});
    wr(0, 32'h3);
    wr(0, 32'h7);
    while (!status[27]) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(status[27] == 1 && status[25:21] == 0, "R8 full level", status[27:21], 64);
    wr(0, 32'h4003);
    wait_idle();
    chk(status[27] == 1, "R8 full kept after drops", status[27], 1);
    // R11 enable cleared by stop
    wr(0, 32'h5);
    bad = 0;
    repeat (30) begin @(negedge clk); if (conv_req) bad++; end
    chk(bad == 0, "R11 enable cleared", bad, 0);

    // R8 same-cycle push and pop on a full queue
    wr(0, 32'h1);
    wr(1, {5'b0, 3'd0, 24'o00000005});
    pop_on_ack = 1'b1;
    wr(0, 32'h5);
    wait_idle();
    pop_on_ack = 1'b0;
    @(negedge clk);
    chk(status[27] == 1 && status[25:21] == 0, "R8 push pop full", status[27:21], 64);
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      logic [2:0] ech;
      ech = (k == 31) ? 3'd5 : ((k % 2 == 0) ? 3'd2 : 3'd1);
      pop1(d);
      if (d[14:12] != ech) bad++;
    end
    chk(bad == 0, "R4 R8 queue order", bad, 0);
    chk(status[26] == 1, "R9 empty after drain", status[26], 1);

    // R10 interrupt threshold 3
    wr(0, 32'h39);
    chk(irq == 0, "R10 irq below threshold", irq, 0);
    wr(1, {5'b0, 3'd3, 24'o00003210});
    wr(0, 32'h3D);
    wait_idle();
    chk(irq == 1 && status[25:21] == 4, "R10 irq at level 4", irq, 1);
    pop1(d);
    chk(irq == 1, "R10 irq at level 3", irq, 1);
    pop1(d);
    chk(irq == 0, "R10 irq at level 2", irq, 0);
    pop1(d);
    pop1(d);

    // R11 stop waits for averaging block
    avg_busy = 1'b1;
    wr(2, 32'h5);
    wr(1, {5'b0, 3'd1, 24'o00000042});
    wr(0, 32'h3);
    wr(0, 32'h7);
    while (status[25:21] < 3) @(negedge clk);
    wr(0, 32'h4003);
    repeat (40) @(negedge clk);
    chk(status[28] == 1 && status[29] == 1, "R11 busy while averaging", status[29:28], 3);
    chk(conv_req == 0, "R11 no new request", conv_req, 1'b0);
    c0 = int'(status[25:21]);
    repeat (10) @(negedge clk);
    chk(int'(status[25:21]) == c0, "R11 no new result", status[25:21], c0);
    avg_busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(status[28] == 0, "R11 idle after averaging", status[28], 0);
    bad = 0;
    for (int k = 0; k < c0; k++) begin
      pop1(d);
      if (d[14:12] != ((k % 2 == 0) ? 3'd2 : 3'd4)) bad++;
    end
    chk(bad == 0, "R4 continuous wrap", bad, 0);

    summary();
    $finish;
  end
endmodule